// File: doc/BRIEF.md
# Multi-Channel ADC Sample Packer

The block sits between a bank of ADC channels and a memory writer. A pulse on `start_i` marks the end of an acquisition. On that pulse the block captures every channel's sample and the channel-enable mask at the same time. It then walks the enabled channels from channel 0 upward. Each sample leaves as two 16-bit halfwords on `word_o`, the low half first.

Every halfword is offered to the memory writer under a level handshake. `wr_o` stays high, with the word held still, until the writer raises `ack_i`. The strobe then drops. The next word is offered only after `ack_i` has gone low again.

When the upper half of the last enabled channel has completed its handshake, `done_o` pulses for one cycle. A transfer with no channels enabled finishes at once, without any writes. The memory writer's base address and length are set up elsewhere, and this block does not generate addresses.

Top module: `adc_word_packer`

## Requirements
- R1: Only channels whose bit is 1 in the mask captured at start produce words. Bit i of `mask_i` enables channel i.
- R2: Enabled channels are emitted in ascending channel index order.
- R3: Each enabled channel produces exactly two words: bits 15:0 of its sample first, then the upper word. A transfer therefore writes 2 × (number of enabled channels) words.
- R4: The upper word holds sample bits 31:16 of the sample zero-extended to 32 bits, so bits above SAMPLE_W-1 read as 0.
- R5: While `wr_o` is high and `ack_i` is low, `wr_o` stays high and `word_o` stays stable. In the cycle after `ack_i` is sampled high, `wr_o` is low.
- R6: After a word is acknowledged, `wr_o` does not rise again until `ack_i` has been sampled low.
- R7: `done_o` is a single-cycle pulse. It occurs in the cycle after `ack_i` returns low for the last upper word, while `wr_o` is low.
- R8: A start with an all-zero mask produces no writes, and `done_o` is high in the cycle after the start.
- R9: Changes to `sample_i` and `mask_i` after the start cycle do not affect the words of that transfer.
- R10: `start_i` is ignored while a transfer is in progress.
- R11: Out of reset, `wr_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Acquisition complete; capture samples and mask, begin transfer |
| sample_i | input | NUM_CH×SAMPLE_W | Per-channel samples, channel i at slice i |
| mask_i | input | NUM_CH | Channel enable mask, bit i enables channel i |
| word_o | output | WORD_W | Halfword offered to the memory writer |
| wr_o | output | 1 | Write strobe, held until acknowledged |
| ack_i | input | 1 | Memory writer acknowledge (level) |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench builds the block with nine channels, 24-bit samples and 16-bit words. With these values a full mask reaches the highest channel, and the zero fill of the upper word's bits 31:24 becomes visible. The memory-writer model varies both the time to acknowledge and the time to release, so the hold and re-arm rules of the handshake are exercised at several gaps. After each start the bench scrambles the inputs, and in one transfer it pulses start a second time mid-transfer, to show that capture and the in-progress guard work.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_DONE
  } pack_state_e;
endpackage

// File: rtl/pack_sample_bank.sv
module pack_sample_bank #(
  parameter int NUM_CH   = 9,
  parameter int SAMPLE_W = 24,
  localparam int IDX_W   = $clog2(NUM_CH)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  sample_i,
  input  logic [NUM_CH-1:0]                mask_i,
  input  logic                             clr_i,
  input  logic [IDX_W-1:0]                 clr_idx_i,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]  samples_o,
  output logic [NUM_CH-1:0]                pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samples_o <= '0;
      pend_o    <= '0;
    end else if (load_i) begin
      samples_o <= sample_i;
      pend_o    <= mask_i;
    end else if (clr_i) begin
      pend_o[clr_idx_i] <= 1'b0;
    end
  end

  // samples frozen between loads
  assert_hold_samples_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(samples_o));
  // pending set only shrinks between loads
  assert_pend_shrink_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((pend_o & ~$past(pend_o)) == '0));
endmodule

// File: rtl/pack_lowest_pick.sv
module pack_lowest_pick #(
  parameter int NUM_CH = 9,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o,
  output logic              more_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end

  assign more_o = |(pend_i & ~(NUM_CH'(1) << idx_o));

  assert_pick_lowest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (pend_i[idx_o] && ((pend_i & ((NUM_CH'(1) << idx_o) - NUM_CH'(1))) == '0)));
endmodule

// File: rtl/pack_ctrl.sv
module pack_ctrl
  import adc_pack_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mask_any_i,
  input  logic more_i,
  input  logic ack_i,
  output logic load_o,
  output logic clr_o,
  output logic half_o,
  output logic wr_o,
  output logic done_o,
  output logic idle_o
);
  pack_state_e st_q, st_d;
  logic half_d;

  always_comb begin
    st_d   = st_q;
    half_d = half_o;
    load_o = 1'b0;
    clr_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        half_d = 1'b0;
        st_d   = mask_any_i ? ST_SEND : ST_DONE;
      end
      ST_SEND: if (ack_i) st_d = ST_WAIT;
      ST_WAIT: if (!ack_i) begin
        if (!half_o) begin
          half_d = 1'b1;
          st_d   = ST_SEND;
        end else begin
          half_d = 1'b0;
          clr_o  = 1'b1;
          st_d   = more_i ? ST_SEND : ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      half_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      half_o <= half_d;
    end
  end

  assign wr_o   = (st_q == ST_SEND);
  assign done_o = (st_q == ST_DONE);
  assign idle_o = (st_q == ST_IDLE);

  assert_wr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !ack_i) |=> wr_o);
  assert_wr_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && ack_i) |=> !wr_o);
  assert_rearm_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && ack_i) |=> !wr_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_no_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |-> !load_o);
endmodule

// File: rtl/adc_word_packer.sv
module adc_word_packer #(
  parameter int NUM_CH   = 9,
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  sample_i,
  input  logic [NUM_CH-1:0]                mask_i,
  output logic [WORD_W-1:0]                word_o,
  output logic                             wr_o,
  input  logic                             ack_i,
  output logic                             done_o
);
  localparam int IDX_W = $clog2(NUM_CH);
  localparam int EXT_W = 2 * WORD_W;

  logic [NUM_CH-1:0][SAMPLE_W-1:0] samples_q;
  logic [NUM_CH-1:0]               pend_q;
  logic [IDX_W-1:0]                cur_idx;
  logic                            any_pend, more_pend;
  logic                            load, clr, half, idle;
  logic [EXT_W-1:0]                cur_ext;

  pack_sample_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_bank (
    .clk_i, .rst_ni,
    .load_i    (load),
    .sample_i  (sample_i),
    .mask_i    (mask_i),
    .clr_i     (clr),
    .clr_idx_i (cur_idx),
    .samples_o (samples_q),
    .pend_o    (pend_q)
  );

  pack_lowest_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk_i, .rst_ni,
    .pend_i (pend_q),
    .idx_o  (cur_idx),
    .any_o  (any_pend),
    .more_o (more_pend)
  );

  pack_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .start_i    (start_i),
    .mask_any_i (|mask_i),
    .more_i     (more_pend),
    .ack_i      (ack_i),
    .load_o     (load),
    .clr_o      (clr),
    .half_o     (half),
    .wr_o       (wr_o),
    .done_o     (done_o),
    .idle_o     (idle)
  );

  // zero-extend so unused upper bits read 0
  assign cur_ext = EXT_W'(samples_q[cur_idx]);
  assign word_o  = half ? cur_ext[EXT_W-1:WORD_W] : cur_ext[WORD_W-1:0];

  assert_word_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !ack_i) |=> $stable(word_o));
  assert_wr_has_chan_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> any_pend);
  assert_zero_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && mask_i == '0) |=> (done_o && !wr_o));
  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!wr_o && pend_q == '0));
endmodule

// File: tb/adc_word_packer_tb.sv
module adc_word_packer_tb;
  localparam int NCH = 9;
  localparam int SW  = 24;
  localparam int WW  = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NCH-1:0][SW-1:0] sample_i = '0;
  logic [NCH-1:0] mask_i = '0;
  logic [WW-1:0] word_o;
  logic wr_o;
  logic ack_i = 1'b0;
  logic done_o;

  always #2 clk_i = ~clk_i;

  adc_word_packer #(.NUM_CH(NCH), .SAMPLE_W(SW), .WORD_W(WW)) u_dut (
    .clk_i, .rst_ni, .start_i, .sample_i, .mask_i,
    .word_o, .wr_o, .ack_i, .done_o
  );

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] exp_q[$];
  int done_cnt = 0;
  int words_seen = 0;
  int wait_cnt = 0;
  int low_cnt = 0;
  int pace = 0;
  bit monitor_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory-writer model and scoreboard monitor
  always @(negedge clk_i) begin
    if (monitor_on) begin
      if (done_o) begin
        done_cnt++;
        chk(exp_q.size() == 0, "R7 queue empty at done", exp_q.size(), 0);
        chk(!wr_o, "R7 no write with done", wr_o, 0);
      end
      if (ack_i) begin
        chk(!wr_o, "R6 write while ack high", wr_o, 0);
        if (low_cnt == 0) ack_i <= 1'b0;
        else low_cnt--;
      end else if (wr_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected write", word_o, 0);
          ack_i <= 1'b1;
        end else begin
          chk(word_o == exp_q[0], "R3/R5 word value", word_o, exp_q[0]);
          if (wait_cnt > 0) wait_cnt--;
          else begin
            void'(exp_q.pop_front());
            words_seen++;
            ack_i    <= 1'b1;
            pace++;
            wait_cnt = pace % 3;
            low_cnt  = (pace / 3) % 3;
          end
        end
      end
    end
  end

  function automatic logic [NCH-1:0][SW-1:0] mk(input int seed);
    logic [NCH-1:0][SW-1:0] s;
    for (int c = 0; c < NCH; c++)
      s[c] = SW'(seed * 32'h9E3779B1 + c * 32'h0123_4567 + 32'h00A5_5A00);
    return s;
  endfunction

  task automatic run_xfer(input logic [NCH-1:0] m, input logic [NCH-1:0][SW-1:0] s,
                          input bit restart);
    int d0, w0, n;
    logic [31:0] ext;
    n = 0;
    d0 = done_cnt;
    w0 = words_seen;
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        ext = 32'(s[c]);
        exp_q.push_back(ext[15:0]);   // R3 low half first
        exp_q.push_back(ext[31:16]);  // R4 upper zero-filled
        n++;
      end
    end
    @(negedge clk_i);
    sample_i = s;
    mask_i   = m;
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i  = 1'b0;
    sample_i = ~s;  // R9 scramble after capture
    mask_i   = ~m;
    if (m == '0) begin
      #1;
      chk(done_o == 1'b1, "R8 done after zero-mask start", done_o, 1);
      chk(wr_o == 1'b0, "R8 no write", wr_o, 0);
    end
    if (restart) begin
      repeat (6) @(negedge clk_i);
      mask_i  = '1;
      start_i = 1'b1;  // R10 ignored mid-transfer
      @(negedge clk_i);
      start_i = 1'b0;
    end
    for (int t = 0; t < 4000 && done_cnt == d0; t++) @(posedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(done_cnt == d0 + 1, "R7/R10 one done per transfer", done_cnt - d0, 1);
    chk(words_seen - w0 == 2 * n, "R3 word count", words_seen - w0, 2 * n);
    chk(exp_q.size() == 0, "R1/R2 all expected words seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(wr_o == 1'b0, "R11 wr low in reset", wr_o, 0);
    chk(done_o == 1'b0, "R11 done low in reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(wr_o == 1'b0 && done_o == 1'b0, "R11 idle after reset", {wr_o, done_o}, 0);
    monitor_on = 1'b1;
    run_xfer(9'b111101011, mk(1), 1'b0);  // R1 sparse mask
    run_xfer(9'h001, '1, 1'b0);           // R4 upper word 0x00FF
    run_xfer(9'h100, mk(2), 1'b0);        // top channel only
    run_xfer(9'h1FF, mk(3), 1'b0);        // R2 full order
    run_xfer(9'h000, mk(4), 1'b0);        // R8
    run_xfer(9'h0AA, mk(5), 1'b1);        // R10
    run_xfer(9'h155, mk(6), 1'b0);        // R9
    run_xfer(9'h000, mk(7), 1'b0);
    run_xfer(9'h181, mk(8), 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule